// File: doc/BRIEF.md
# Pipelined Integer Stream ALU

This block is the integer arithmetic-logic unit of a single lane in a stream-processing cluster. Each clock cycle it can accept one operation: a 4-bit opcode and two 32-bit operands, qualified by a valid flag. Two cycles later, the 32-bit result appears on a result port together with its own valid flag. The operands come from the lane's private register bank, and the results go back into that bank. Register storage and instruction decode sit outside this block.

The operation set is fixed at thirteen operations:

- add, subtract and absolute value;
- four bitwise functions;
- left logical, right logical and right arithmetic shift;
- signed less-than, signed greater-than and equality compares.

Both the adder path and the compare path use two-level carry-lookahead adders. The first pipeline stage captures the issued operation. The second stage evaluates it and registers the result. The unit takes an asynchronous active-low reset that is released synchronously inside the block.

Top module: `stream_alu`

## Requirements
- R1: Opcode 0 is ADD. It returns A+B modulo 2^32.
- R2: Opcode 1 is SUB. It returns A-B modulo 2^32 (two's complement).
- R3: Opcode 2 is ABS. It returns |A| with A taken as signed. The value 32'h8000_0000 is returned unchanged.
- R4: Opcode 3 is AND, opcode 4 is OR and opcode 5 is XOR. Each is bitwise over all 32 bits of A and B.
- R5: Opcode 6 is NOT. It returns ~A, and the value of B has no effect on the result.
- R6: Opcode 7 is SLL and opcode 8 is SRL. Each shifts A by the amount in B[4:0] and fills with zeros. B[31:5] has no effect on the result.
- R7: Opcode 9 is SRA. It shifts A right by B[4:0] and fills with copies of A[31].
- R8: Opcode 10 (LT) and opcode 11 (GT) compare A with B as signed values. Each returns 32'd1 when the relation holds and 32'd0 otherwise, including when A equals B.
- R9: Opcode 12 is EQ. It returns 32'd1 when A equals B and 32'd0 otherwise.
- R10: The result port `out_valid` equals `in_valid` from two clock edges earlier. A new operation may be issued on every cycle, and each result belongs to the operation issued two cycles before it.
- R11: While `rst_n` is low, `out_valid` and `out_result` read zero, and any operation in flight is discarded.
- R12: Opcodes 13, 14 and 15 are unassigned. Issuing one produces a valid result of 32'd0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue qualifier for in_op, in_a and in_b |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand (shift amount in bits 4:0) |
| out_valid | output | 1 | Result qualifier, in_valid delayed by two cycles |
| out_result | output | 32 | Operation result |

## Verification
The arithmetic operations are driven with values on both sides of the sign boundary and with carries that ripple through every lookahead group, such as all-ones plus one. These cases separate a correct carry chain from one that drops a group carry. The compares are driven with equal operands, operands of mixed sign, and the extreme values 32'h7FFF_FFFF and 32'h8000_0000. Those extreme pairs overflow in the internal subtraction, so they show whether the sign correction is present. Shifts are driven with amounts 0, 1, 16 and 31, with upper bits of B set to junk, and with a negative A; this separates the three fill rules and the masking of the shift amount. A back-to-back burst with a gap in the middle checks that results keep their order and their two-cycle spacing.

// File: rtl/salu_pkg.sv
package salu_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned GROUP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_ABS = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_NOT = 4'd6,
    OP_SLL = 4'd7,
    OP_SRL = 4'd8,
    OP_SRA = 4'd9,
    OP_LT  = 4'd10,
    OP_GT  = 4'd11,
    OP_EQ  = 4'd12
  } salu_op_e;

endpackage

// File: rtl/salu_rst_sync.sv
module salu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/salu_cla.sv
// Two-level carry-lookahead adder: group generate/propagate terms feed a
// group carry chain, and each bit carry is looked ahead from its group entry.
module salu_cla #(
  parameter int unsigned W  = 32,
  parameter int unsigned GW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);

  localparam int unsigned NG = W / GW;

  logic [W-1:0]  gen_b;
  logic [W-1:0]  prop_b;
  logic [NG-1:0] grp_gen;
  logic [NG-1:0] grp_prop;
  logic [W-1:0]  carry;

  assign gen_b  = a & b;
  assign prop_b = a ^ b;

  always_comb begin
    logic gg;
    logic pp;
    for (int j = 0; j < NG; j++) begin
      gg = 1'b0;
      pp = 1'b1;
      for (int k = 0; k < GW; k++) begin
        gg = gen_b[j*GW+k] | (prop_b[j*GW+k] & gg);
        pp = pp & prop_b[j*GW+k];
      end
      grp_gen[j]  = gg;
      grp_prop[j] = pp;
    end
  end

  always_comb begin
    logic entry;
    logic la;
    entry = cin;
    for (int j = 0; j < NG; j++) begin
      for (int k = 0; k < GW; k++) begin
        la = entry;
        for (int m = 0; m < k; m++) begin
          la = gen_b[j*GW+m] | (prop_b[j*GW+m] & la);
        end
        carry[j*GW+k] = la;
      end
      entry = grp_gen[j] | (grp_prop[j] & entry);
    end
  end

  assign sum = prop_b ^ carry;

endmodule

// File: rtl/salu_cmp.sv
// Signed magnitude comparator built on its own lookahead subtractor.
module salu_cmp #(
  parameter int unsigned W  = 32,
  parameter int unsigned GW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt,
  output logic         gt,
  output logic         eq
);

  logic [W-1:0] diff;
  logic         ovf;

  salu_cla #(.W(W), .GW(GW)) u_sub (
    .a   (a),
    .b   (~b),
    .cin (1'b1),
    .sum (diff)
  );

  assign ovf = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
  assign eq  = ~|diff;
  assign lt  = diff[W-1] ^ ovf;
  assign gt  = ~lt & ~eq;

endmodule

// File: rtl/salu_shift.sv
// Logarithmic shifter. Left shifts reuse the right-shift stages through bit
// reversal on input and output.
module salu_shift #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  dout
);

  logic [W-1:0] din_rev;
  logic [W-1:0] rin;
  logic [W-1:0] rout;
  logic [W-1:0] rout_rev;
  logic         fill;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign din_rev[i]  = din[W-1-i];
    assign rout_rev[i] = rout[W-1-i];
  end

  assign rin  = left ? din_rev : din;
  assign fill = arith & ~left & din[W-1];

  for (genvar s = 0; s < SW; s++) begin : g_stg
    localparam int unsigned SH = 1 << s;
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      assign q = amt[s] ? {{SH{fill}}, rin[W-1:SH]} : rin;
    end else begin : g_next
      assign q = amt[s] ? {{SH{fill}}, g_stg[s-1].q[W-1:SH]} : g_stg[s-1].q;
    end
  end

  assign rout = g_stg[SW-1].q;
  assign dout = left ? rout_rev : rout;

endmodule

// File: rtl/stream_alu.sv
module stream_alu
  import salu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [3:0]  in_op,
  input  logic [31:0] in_a,
  input  logic [31:0] in_b,
  output logic        out_valid,
  output logic [31:0] out_result
);

  localparam int unsigned SHW = $clog2(DATA_W);

  logic rst_sync_n;

  salu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Stage 1: issue capture
  logic              s1_vld_q, s1_vld_d;
  salu_op_e          s1_op_q,  s1_op_d;
  logic [DATA_W-1:0] s1_a_q,   s1_a_d;
  logic [DATA_W-1:0] s1_b_q,   s1_b_d;
  logic              s1_en;

  always_comb begin
    s1_en    = in_valid;
    s1_vld_d = in_valid;
    s1_op_d  = salu_op_e'(in_op);
    s1_a_d   = in_a;
    s1_b_d   = in_b;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_vld_q <= 1'b0;
      s1_op_q  <= OP_ADD;
      s1_a_q   <= '0;
      s1_b_q   <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      if (s1_en) begin
        s1_op_q <= s1_op_d;
        s1_a_q  <= s1_a_d;
        s1_b_q  <= s1_b_d;
      end
    end
  end

  // Stage 2: evaluate
  logic [DATA_W-1:0] add_x, add_y, add_y_eff, add_sum;
  logic              add_sub;

  always_comb begin
    add_x   = s1_a_q;
    add_y   = s1_b_q;
    add_sub = 1'b0;
    unique case (s1_op_q)
      OP_SUB: add_sub = 1'b1;
      OP_ABS: begin
        add_x   = '0;
        add_y   = s1_a_q;
        add_sub = s1_a_q[DATA_W-1];
      end
      default: add_sub = 1'b0;
    endcase
    add_y_eff = add_sub ? ~add_y : add_y;
  end

  salu_cla #(.W(DATA_W), .GW(GROUP_W)) u_add (
    .a   (add_x),
    .b   (add_y_eff),
    .cin (add_sub),
    .sum (add_sum)
  );

  logic cmp_lt, cmp_gt, cmp_eq;

  salu_cmp #(.W(DATA_W), .GW(GROUP_W)) u_cmp (
    .a  (s1_a_q),
    .b  (s1_b_q),
    .lt (cmp_lt),
    .gt (cmp_gt),
    .eq (cmp_eq)
  );

  logic [DATA_W-1:0] shf_out;
  logic              shf_left, shf_arith;

  assign shf_left  = (s1_op_q == OP_SLL);
  assign shf_arith = (s1_op_q == OP_SRA);

  salu_shift #(.W(DATA_W), .SW(SHW)) u_shf (
    .din   (s1_a_q),
    .amt   (s1_b_q[SHW-1:0]),
    .left  (shf_left),
    .arith (shf_arith),
    .dout  (shf_out)
  );

  logic              s2_vld_q, s2_vld_d;
  logic [DATA_W-1:0] s2_res_q, s2_res_d;
  logic              s2_en;

  always_comb begin
    s2_en    = s1_vld_q;
    s2_vld_d = s1_vld_q;
    case (s1_op_q)
      OP_ADD, OP_SUB, OP_ABS: s2_res_d = add_sum;
      OP_AND: s2_res_d = s1_a_q & s1_b_q;
      OP_OR:  s2_res_d = s1_a_q | s1_b_q;
      OP_XOR: s2_res_d = s1_a_q ^ s1_b_q;
      OP_NOT: s2_res_d = ~s1_a_q;
      OP_SLL, OP_SRL, OP_SRA: s2_res_d = shf_out;
      OP_LT:  s2_res_d = {{(DATA_W-1){1'b0}}, cmp_lt};
      OP_GT:  s2_res_d = {{(DATA_W-1){1'b0}}, cmp_gt};
      OP_EQ:  s2_res_d = {{(DATA_W-1){1'b0}}, cmp_eq};
      default: s2_res_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s2_vld_q <= 1'b0;
      s2_res_q <= '0;
    end else begin
      s2_vld_q <= s2_vld_d;
      if (s2_en) s2_res_q <= s2_res_d;
    end
  end

  assign out_valid  = s2_vld_q;
  assign out_result = s2_res_q;

endmodule

// File: rtl/stream_alu_chk.sv
module stream_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  in_op,
  input logic [31:0] in_a,
  input logic [31:0] in_b,
  input logic        out_valid,
  input logic [31:0] out_result
);

  logic [1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hist_q <= 2'd0;
    else if (hist_q != 2'd2) hist_q <= hist_q + 2'd1;
  end

  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R8
  compare_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hist_q == 2'd2) && $past(in_valid, 2) &&
     ($past(in_op, 2) >= 4'd10) && ($past(in_op, 2) <= 4'd12))
    |-> (out_result[31:1] == 31'd0));

  // R9
  eq_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hist_q == 2'd2) && $past(in_valid, 2) && ($past(in_op, 2) == 4'd12) &&
     ($past(in_a, 2) == $past(in_b, 2)))
    |-> (out_result == 32'd1));

  // R5
  not_only_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hist_q == 2'd2) && $past(in_valid, 2) && ($past(in_op, 2) == 4'd6))
    |-> (out_result == ~$past(in_a, 2)));

  // R12
  unused_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hist_q == 2'd2) && $past(in_valid, 2) && ($past(in_op, 2) >= 4'd13))
    |-> (out_result == 32'd0));

  // R11
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (!out_valid && (out_result == 32'd0));
    end
  end

endmodule

bind stream_alu stream_alu_chk u_chk (.*);

// File: tb/tb_stream_alu.sv
module tb_stream_alu;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  localparam logic [3:0] C_ADD = 4'd0,  C_SUB = 4'd1,  C_ABS = 4'd2;
  localparam logic [3:0] C_AND = 4'd3,  C_OR  = 4'd4,  C_XOR = 4'd5;
  localparam logic [3:0] C_NOT = 4'd6,  C_SLL = 4'd7,  C_SRL = 4'd8;
  localparam logic [3:0] C_SRA = 4'd9,  C_LT  = 4'd10, C_GT  = 4'd11;
  localparam logic [3:0] C_EQ  = 4'd12;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [31:0] in_a;
  logic [31:0] in_b;
  logic        out_valid;
  logic [31:0] out_result;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  stream_alu dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model(input logic [3:0] op,
                                        input logic [31:0] a,
                                        input logic [31:0] b);
    case (op)
      C_ADD: return a + b;
      C_SUB: return a - b;
      C_ABS: return a[31] ? (32'd0 - a) : a;
      C_AND: return a & b;
      C_OR:  return a | b;
      C_XOR: return a ^ b;
      C_NOT: return ~a;
      C_SLL: return a << b[4:0];
      C_SRL: return a >> b[4:0];
      C_SRA: return $unsigned($signed(a) >>> b[4:0]);
      C_LT:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      C_GT:  return ($signed(a) > $signed(b)) ? 32'd1 : 32'd0;
      C_EQ:  return (a == b) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Issue one operation, then sample its result two edges later.
  task automatic run_op(input string req, input logic [3:0] op,
                        input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0; in_a = ~a; in_b = ~b;
    @(negedge clk);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_result, model(op, a, b));
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_op = 4'd0; in_a = '0; in_b = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R11 reset valid",  {31'd0, out_valid}, 32'd0);
    check("R11 reset result", out_result, 32'd0);
  endtask

  task automatic t_add_sub();
    run_op("R1 add small",        C_ADD, 32'd5, 32'd7);
    run_op("R1 add full carry",   C_ADD, 32'hFFFF_FFFF, 32'd1);
    run_op("R1 add group carry",  C_ADD, 32'h0FFF_FFFF, 32'h0000_0001);
    run_op("R1 add mixed",        C_ADD, 32'h1234_5678, 32'h9ABC_DEF0);
    run_op("R2 sub positive",     C_SUB, 32'd100, 32'd58);
    run_op("R2 sub borrow",       C_SUB, 32'd0, 32'd1);
    run_op("R2 sub min",          C_SUB, 32'h8000_0000, 32'd1);
  endtask

  task automatic t_abs();
    run_op("R3 abs positive", C_ABS, 32'd1234, 32'hDEAD_BEEF);
    run_op("R3 abs negative", C_ABS, 32'hFFFF_FFF6, 32'd0);
    run_op("R3 abs min",      C_ABS, 32'h8000_0000, 32'd3);
    run_op("R3 abs zero",     C_ABS, 32'd0, 32'd9);
  endtask

  task automatic t_logic();
    run_op("R4 and", C_AND, 32'hF0F0_A5A5, 32'hFF00_0FF0);
    run_op("R4 or",  C_OR,  32'hF0F0_A5A5, 32'h0F00_5A0A);
    run_op("R4 xor", C_XOR, 32'hFFFF_0000, 32'hAAAA_AAAA);
  endtask

  task automatic t_not();
    run_op("R5 not b zero", C_NOT, 32'h1357_9BDF, 32'd0);
    run_op("R5 not b ones", C_NOT, 32'h1357_9BDF, 32'hFFFF_FFFF);
  endtask

  task automatic t_shift();
    run_op("R6 sll 0",        C_SLL, 32'h8000_0001, 32'd0);
    run_op("R6 sll 1",        C_SLL, 32'h8000_0001, 32'd1);
    run_op("R6 sll 31",       C_SLL, 32'h0000_0003, 32'd31);
    run_op("R6 sll b high",   C_SLL, 32'h0000_00FF, 32'hFFFF_FFE4);
    run_op("R6 srl 16",       C_SRL, 32'h8765_4321, 32'd16);
    run_op("R6 srl b high",   C_SRL, 32'h8000_0000, 32'h0000_0F3F);
    run_op("R7 sra neg 4",    C_SRA, 32'h8765_4321, 32'd4);
    run_op("R7 sra neg 31",   C_SRA, 32'h8000_0000, 32'd31);
    run_op("R7 sra pos 8",    C_SRA, 32'h7654_3210, 32'd8);
  endtask

  task automatic t_compare();
    run_op("R8 lt true mixed",  C_LT, 32'hFFFF_FFFF, 32'd1);
    run_op("R8 lt equal",       C_LT, 32'd42, 32'd42);
    run_op("R8 lt overflow",    C_LT, 32'h8000_0000, 32'h7FFF_FFFF);
    run_op("R8 gt overflow",    C_GT, 32'h7FFF_FFFF, 32'h8000_0000);
    run_op("R8 gt equal",       C_GT, 32'h8000_0000, 32'h8000_0000);
    run_op("R8 gt false",       C_GT, 32'd3, 32'd9);
    run_op("R9 eq true",        C_EQ, 32'hCAFE_F00D, 32'hCAFE_F00D);
    run_op("R9 eq false",       C_EQ, 32'hCAFE_F00D, 32'hCAFE_F00C);
  endtask

  task automatic t_unused_ops();
    run_op("R12 op 13", 4'd13, 32'hFFFF_FFFF, 32'h1234_5678);
    run_op("R12 op 15", 4'd15, 32'h5555_5555, 32'hAAAA_AAAA);
  endtask

  // Back-to-back issue with a bubble at slot 3.
  task automatic t_pipeline();
    logic [3:0]  ops [8];
    logic [31:0] as  [8];
    logic [31:0] bs  [8];
    logic        vs  [8];
    for (int i = 0; i < 8; i++) begin
      ops[i] = 4'(i % 13);
      as[i]  = 32'h1111_1111 * (i + 1);
      bs[i]  = 32'h0101_0003 + i;
      vs[i]  = (i != 3);
    end
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R10 pipe valid", {31'd0, out_valid}, {31'd0, vs[i-2]});
        if (vs[i-2]) check("R10 pipe result", out_result,
                           model(ops[i-2], as[i-2], bs[i-2]));
      end
      if (i < 8) begin
        in_valid = vs[i]; in_op = ops[i]; in_a = as[i]; in_b = bs[i];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_reset_in_flight();
    @(negedge clk);
    in_valid = 1'b1; in_op = C_ADD; in_a = 32'd1; in_b = 32'd2;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R11 flight valid",  {31'd0, out_valid}, 32'd0);
    check("R11 flight result", out_result, 32'd0);
    @(negedge clk);
    check("R11 flight drop", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 after release", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_op = 4'd0; in_a = '0; in_b = '0;
    #1;
    t_reset_state();
    do_reset();
    t_reset_state();
    t_add_sub();
    t_abs();
    t_logic();
    t_not();
    t_shift();
    t_compare();
    t_unused_ops();
    t_pipeline();
    t_reset_in_flight();
    t_add_sub();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", WATCHDOG_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule